// File: doc/BRIEF.md
# Shared Framebuffer Fetch Arbiter

This block lets a processor and a one-bit-per-pixel display share a single-port memory. The display side keeps a current word in a pixel shift register and a spare word in a holding register. A fixed number of pixel clocks before the current word runs out, the display side raises a fetch request. At the next processor-cycle boundary the request becomes a grant. The grant stalls the processor for exactly one processor cycle and points the memory address at the video address counter. The word that the memory returns one processor cycle later goes into the holding register. At the word boundary the holding register moves into the shifter.

The whole block runs on the pixel clock. The processor cycle is marked by `cpu_en`, which is high in the last pixel cycle of each processor cycle. With a ratio of three, a 32-pixel word lasts about 10.67 processor cycles. During active lines, roughly one processor cycle in ten is lost to the stall. The `frame_start` pulse does three things: it rewinds the video address to the framebuffer base, empties both registers, and issues a single prefetch so that the first pixel of the frame is ready. Line timing comes from outside through `pix_active`. Active line lengths are a multiple of the word width, and the framebuffer is read contiguously across lines.

Top module: `fb_fetch_arbiter`

## Requirements
- R1: While reset is held, `cpu_stall`, `vid_req` and `pix_out` are 0, `mem_addr` equals `cpu_addr` and `mem_we` equals `cpu_we`.
- R2: While `cpu_stall` is 1, `mem_addr` carries the video address and `mem_we` is 0. While `cpu_stall` is 0, `mem_addr`, `mem_we` and `mem_wdata` follow `cpu_addr`, `cpu_we` and `cpu_wdata`.
- R3: Each stall lasts exactly one processor cycle (CPU_RATIO pixel clocks) and drops right after the `cpu_en` cycle that ends it.
- R4: One pixel cycle after a `frame_start` cycle, `vid_req` is 1. The first fetch of the frame reads address BASE_ADDR, and each later fetch reads the address one above the previous fetch.
- R5: During active video, `vid_req` rises only in the pixel cycle whose position in the current word is WORD_W-LEAD, counting positions from 0. It rises once per word.
- R6: `cpu_stall` rises exactly in the pixel cycle after a cycle in which `cpu_en` and `vid_req` were 1 and `cpu_stall` was 0. It rises at no other time.
- R7: Active pixels appear on `pix_out` one per pixel clock and continue across word and line boundaries. Active pixel n of a frame is bit WORD_W-1-(n mod WORD_W) of the word at BASE_ADDR + n/WORD_W, so each word goes out MSB first.
- R8: No request rises while `pix_active` is low, except the prefetch that follows `frame_start`.
- R9: A processor write that meets a stall is held off and completes on a later unstalled processor cycle, with nothing lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_en | input | 1 | High in the last pixel cycle of each processor cycle |
| frame_start | input | 1 | One-cycle frame start pulse, given during vertical blanking |
| pix_active | input | 1 | High during visible pixels |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_we | input | 1 | Processor write enable |
| cpu_wdata | input | WORD_W | Processor write data |
| mem_addr | output | ADDR_W | Memory word address after the multiplexer |
| mem_we | output | 1 | Memory write enable, gated off during a stall |
| mem_wdata | output | WORD_W | Memory write data |
| mem_rdata | input | WORD_W | Memory read data, valid one processor cycle after the address |
| cpu_stall | output | 1 | Processor stall, high during the display grant cycle |
| vid_req | output | 1 | Display fetch request, high from request until end of grant |
| pix_out | output | 1 | Current pixel |

## Verification
The hardest case to reach is a request that lands on each of the three phases of the processor cycle. The wait for a grant, and so the margin before the word boundary, depends on that phase. The stimulus makes every blanking interval a different length, and the vertical blanking grows by one cycle per frame. Over the sequence, every word boundary meets every `cpu_en` phase. A processor model keeps writes going throughout, so that stalls fall on pending writes.

// File: rtl/fb_arb_pkg.sv
`timescale 1ns/1ps
package fb_arb_pkg;
   typedef enum logic [1:0] {
      FS_IDLE  = 2'd0,
      FS_PEND  = 2'd1,
      FS_GRANT = 2'd2,
      FS_FILL  = 2'd3
   } fetch_st_e;
endpackage

// File: rtl/fb_addr_gen.sv
`timescale 1ns/1ps
module fb_addr_gen #(
   parameter int ADDR_W    = 16,
   parameter int BASE_ADDR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              adv,
   output logic [ADDR_W-1:0] vid_addr
);
   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         vid_addr <= BASE;
      else if (frame_start)
         vid_addr <= BASE;
      else if (adv)
         vid_addr <= vid_addr + 1'b1;
   end
endmodule

// File: rtl/fb_fetch_ctl.sv
`timescale 1ns/1ps
module fb_fetch_ctl
   import fb_arb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_en,
   input  logic frame_start,
   input  logic need_word,
   output logic vid_req,
   output logic grant,
   output logic fill,
   output logic adv
);
   fetch_st_e st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st_q <= FS_IDLE;
      else if (frame_start)
         st_q <= FS_PEND;
      else begin
         case (st_q)
            FS_IDLE:  if (need_word) st_q <= FS_PEND;
            FS_PEND:  if (cpu_en)    st_q <= FS_GRANT;
            FS_GRANT: if (cpu_en)    st_q <= FS_FILL;
            default:                 st_q <= FS_IDLE;
         endcase
      end
   end

   always_comb begin
      vid_req = (st_q == FS_PEND) || (st_q == FS_GRANT);
      grant   = (st_q == FS_GRANT);
      fill    = (st_q == FS_FILL);
      adv     = grant && cpu_en && !frame_start;
   end
endmodule

// File: rtl/fb_pix_shifter.sv
`timescale 1ns/1ps
module fb_pix_shifter #(
   parameter int WORD_W    = 32,
   parameter int LEAD      = 12,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              pix_active,
   input  logic              fill,
   input  logic [WORD_W-1:0] rdata,
   output logic              need_word,
   output logic              pix
);
   localparam int CNT_W  = $clog2(WORD_W);
   localparam int REQ_AT = WORD_W - LEAD - 1;
   localparam logic [CNT_W-1:0] LAST   = CNT_W'(WORD_W - 1);
   localparam logic [CNT_W-1:0] REQ_CN = CNT_W'(REQ_AT);

   logic [WORD_W-1:0] sh_q, hold_q, sh_next;
   logic [CNT_W-1:0]  cnt_q;
   logic              sh_vld, hold_vld;

   generate
      if (MSB_FIRST) begin : g_msb
         assign pix     = sh_q[WORD_W-1];
         assign sh_next = {sh_q[WORD_W-2:0], 1'b0};
      end else begin : g_lsb
         assign pix     = sh_q[0];
         assign sh_next = {1'b0, sh_q[WORD_W-1:1]};
      end
   endgenerate

   assign need_word = pix_active && sh_vld && !hold_vld && !frame_start &&
                      (cnt_q == REQ_CN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q     <= '0;
         hold_q   <= '0;
         cnt_q    <= '0;
         sh_vld   <= 1'b0;
         hold_vld <= 1'b0;
      end else if (frame_start) begin
         cnt_q    <= '0;
         sh_vld   <= 1'b0;
         hold_vld <= 1'b0;
      end else begin
         if (fill && !sh_vld) begin
            sh_q   <= rdata;
            cnt_q  <= '0;
            sh_vld <= 1'b1;
         end else if (pix_active && sh_vld) begin
            if (cnt_q == LAST) begin
               sh_q     <= hold_q;
               cnt_q    <= '0;
               sh_vld   <= hold_vld;
               hold_vld <= 1'b0;
            end else begin
               sh_q  <= sh_next;
               cnt_q <= cnt_q + 1'b1;
            end
         end
         if (fill && sh_vld) begin
            hold_q   <= rdata;
            hold_vld <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/fb_fetch_arbiter.sv
`timescale 1ns/1ps
module fb_fetch_arbiter #(
   parameter int WORD_W    = 32,
   parameter int ADDR_W    = 16,
   parameter int BASE_ADDR = 0,
   parameter int LEAD      = 12,
   parameter int CPU_RATIO = 3,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_en,
   input  logic              frame_start,
   input  logic              pix_active,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_we,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              cpu_stall,
   output logic              vid_req,
   output logic              pix_out
);
   // worst path: wait for boundary, grant cycle, one latch cycle
   localparam int MIN_LEAD = 2 * CPU_RATIO + 2;

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("WORD_W must be at least 2");
      end
      if (CPU_RATIO < 1) begin : g_bad_ratio
         $error("CPU_RATIO must be at least 1");
      end
      if (LEAD < MIN_LEAD || LEAD > WORD_W - 1) begin : g_bad_lead
         $error("LEAD must lie between 2*CPU_RATIO+2 and WORD_W-1");
      end
      if (BASE_ADDR < 0 || BASE_ADDR >= (2 ** ADDR_W)) begin : g_bad_base
         $error("BASE_ADDR must fit in ADDR_W bits");
      end
   endgenerate

   logic              need_word, grant, fill, adv;
   logic [ADDR_W-1:0] vid_addr;

   fb_fetch_ctl i_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cpu_en      (cpu_en),
      .frame_start (frame_start),
      .need_word   (need_word),
      .vid_req     (vid_req),
      .grant       (grant),
      .fill        (fill),
      .adv         (adv)
   );

   fb_addr_gen #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR)
   ) i_addr (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .adv         (adv),
      .vid_addr    (vid_addr)
   );

   fb_pix_shifter #(
      .WORD_W    (WORD_W),
      .LEAD      (LEAD),
      .MSB_FIRST (MSB_FIRST)
   ) i_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .pix_active  (pix_active),
      .fill        (fill),
      .rdata       (mem_rdata),
      .need_word   (need_word),
      .pix         (pix_out)
   );

   always_comb begin
      cpu_stall = grant;
      mem_addr  = grant ? vid_addr : cpu_addr;
      mem_we    = cpu_we && !grant;
      mem_wdata = cpu_wdata;
   end
endmodule

// File: rtl/fb_fetch_arbiter_chk.sv
`timescale 1ns/1ps
module fb_fetch_arbiter_chk #(
   parameter int ADDR_W    = 16,
   parameter int BASE_ADDR = 0,
   parameter int CPU_RATIO = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_en,
   input logic              frame_start,
   input logic              pix_active,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_we,
   input logic              cpu_stall,
   input logic              vid_req,
   input logic [ADDR_W-1:0] vid_addr
);
   logic [7:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else if (cpu_stall)
         run_q <= run_q + 1'b1;
      else
         run_q <= '0;
   end

   assert_mux_video_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_stall |-> (mem_addr == vid_addr) && !mem_we);

   assert_mux_cpu_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_stall |-> (mem_addr == cpu_addr) && (mem_we == cpu_we));

   assert_stall_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_stall) |-> (run_q == 8'(CPU_RATIO)));

   assert_stall_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_stall && cpu_en && !frame_start) |=> !cpu_stall);

   assert_frame_prefetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> vid_req && (vid_addr == ADDR_W'(BASE_ADDR)));

   assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cpu_stall) && !$past(frame_start)) |->
         (vid_addr == ADDR_W'($past(vid_addr) + 1'b1)));

   assert_stall_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_en && vid_req && !cpu_stall && !frame_start) |=> cpu_stall);

   assert_no_blank_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vid_req) |-> ($past(pix_active) || $past(frame_start)));
endmodule

bind fb_fetch_arbiter fb_fetch_arbiter_chk #(
   .ADDR_W    (ADDR_W),
   .BASE_ADDR (BASE_ADDR),
   .CPU_RATIO (CPU_RATIO)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cpu_en      (cpu_en),
   .frame_start (frame_start),
   .pix_active  (pix_active),
   .cpu_addr    (cpu_addr),
   .cpu_we      (cpu_we),
   .mem_addr    (mem_addr),
   .mem_we      (mem_we),
   .cpu_stall   (cpu_stall),
   .vid_req     (vid_req),
   .vid_addr    (vid_addr)
);

// File: tb/test_fb_fetch_arbiter.sv
`timescale 1ns/1ps
module test_fb_fetch_arbiter;
   localparam int CLK_PERIOD = 10;
   localparam int WORD_W     = 32;
   localparam int ADDR_W     = 8;
   localparam int BASE_ADDR  = 'h10;
   localparam int LEAD       = 8;
   localparam int CPU_RATIO  = 3;
   localparam int LINE_PIX   = 64;
   localparam int LINES      = 3;
   localparam int FRAMES     = 4;
   localparam int N_WR       = 60;
   localparam int WR_BASE    = 'h80;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              cpu_en, frame_start, pix_active;
   logic [ADDR_W-1:0] cpu_addr;
   logic              cpu_we;
   logic [WORD_W-1:0] cpu_wdata;
   logic [ADDR_W-1:0] mem_addr;
   logic              mem_we;
   logic [WORD_W-1:0] mem_wdata;
   logic [WORD_W-1:0] mem_rdata;
   logic              cpu_stall, vid_req, pix_out;

   logic [WORD_W-1:0] mem [0:255];

   int total = 0;
   int bad   = 0;
   int wr_done = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fb_fetch_arbiter #(
      .WORD_W    (WORD_W),
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR),
      .LEAD      (LEAD),
      .CPU_RATIO (CPU_RATIO),
      .MSB_FIRST (1'b1)
   ) i_fb_fetch_arbiter (
      .clk         (clk),
      .rst_n       (rst_n),
      .cpu_en      (cpu_en),
      .frame_start (frame_start),
      .pix_active  (pix_active),
      .cpu_addr    (cpu_addr),
      .cpu_we      (cpu_we),
      .cpu_wdata   (cpu_wdata),
      .mem_addr    (mem_addr),
      .mem_we      (mem_we),
      .mem_wdata   (mem_wdata),
      .mem_rdata   (mem_rdata),
      .cpu_stall   (cpu_stall),
      .vid_req     (vid_req),
      .pix_out     (pix_out)
   );

   function automatic logic [WORD_W-1:0] fb_word(input int a);
      return (32'(a) * 32'h9E37_79B9) ^ (32'(a) << 11) ^ 32'h5A3C_0F96;
   endfunction

   function automatic logic [WORD_W-1:0] wr_word(input int n);
      return (32'(n) * 32'h0101_0101) ^ 32'hA5A5_0000;
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // memory model: registered read, one processor cycle of latency
   initial begin
      for (int i = 0; i < 256; i++) mem[i] = fb_word(i);
   end
   always @(posedge clk) begin
      if (cpu_en) begin
         if (mem_we) mem[mem_addr] <= mem_wdata;
         mem_rdata <= mem[mem_addr];
      end
   end

   // processor cycle marker
   initial begin
      cpu_en = 1'b0;
      forever begin
         for (int ph = 0; ph < CPU_RATIO; ph++) begin
            @(posedge clk); #1;
            cpu_en = (ph == CPU_RATIO - 2) || (CPU_RATIO == 1);
         end
      end
   end

   // processor model: one write per processor cycle, held while stalled
   initial begin
      bit go;
      int n;
      n = 0;
      cpu_addr  = ADDR_W'(WR_BASE);
      cpu_we    = 1'b0;
      cpu_wdata = wr_word(0);
      @(posedge rst_n);
      @(posedge clk); #1;
      cpu_we = 1'b1;
      forever begin
         @(negedge clk);
         go = cpu_en && !cpu_stall && cpu_we;
         @(posedge clk); #1;
         if (go) begin
            wr_done++;
            n++;
            if (n >= N_WR) cpu_we = 1'b0;
            else begin
               cpu_addr  = ADDR_W'(WR_BASE + n);
               cpu_wdata = wr_word(n);
            end
         end
      end
   end

   // monitor, sampling at the falling edge
   initial begin
      bit st_prev, trig_prev, fs_prev, req_prev;
      int run, k, p, reqs;
      logic [ADDR_W-1:0] exp_va;
      st_prev = 0; trig_prev = 0; fs_prev = 0; req_prev = 0;
      run = 0; k = 0; p = 0; reqs = 0; exp_va = '0;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            chk(cpu_stall == 1'b0 && vid_req == 1'b0 && pix_out == 1'b0,
                "R1 reset outputs", {cpu_stall, vid_req, pix_out}, 0);
            chk(mem_addr == cpu_addr && mem_we == cpu_we,
                "R1 reset mux", mem_addr, cpu_addr);
         end else begin
            // R6: stall rises exactly after a cpu_en cycle with a request
            if ((cpu_stall && !st_prev) || trig_prev)
               chk((cpu_stall && !st_prev) == trig_prev, "R6 stall start",
                   cpu_stall, trig_prev);
            // R4: address sequence
            if (cpu_stall && !st_prev) begin
               exp_va = ADDR_W'(BASE_ADDR + k);
               chk(mem_addr == exp_va, "R4 fetch address", mem_addr, exp_va);
               k++;
            end
            // R2: multiplexer and write gating
            if (cpu_stall)
               chk(mem_addr == exp_va && !mem_we, "R2 video side",
                   {mem_we, mem_addr}, {1'b0, exp_va});
            else
               chk(mem_addr == cpu_addr && mem_we == cpu_we && mem_wdata == cpu_wdata,
                   "R2 processor side", {mem_we, mem_addr}, {cpu_we, cpu_addr});
            // R3: stall length
            if (cpu_stall) run++;
            else if (st_prev) begin
               chk(run == CPU_RATIO, "R3 stall length", run, CPU_RATIO);
               run = 0;
            end
            // R4 prefetch, R5 request position, R8 quiet blanking
            if (fs_prev)
               chk(vid_req, "R4 prefetch request", vid_req, 1);
            else if (vid_req && !req_prev) begin
               chk(pix_active, "R8 request in blanking", pix_active, 1);
               chk((p % WORD_W) == WORD_W - LEAD, "R5 request position",
                   p % WORD_W, WORD_W - LEAD);
               reqs++;
            end
            // R7: pixel stream
            if (pix_active) begin
               logic [WORD_W-1:0] w;
               w = fb_word(BASE_ADDR + p / WORD_W);
               chk(pix_out == w[WORD_W - 1 - (p % WORD_W)], "R7 pixel",
                   pix_out, w[WORD_W - 1 - (p % WORD_W)]);
               p++;
            end
            if (frame_start) begin
               if (p != 0)
                  chk(reqs == p / WORD_W, "R5 one request per word", reqs, p / WORD_W);
               p = 0; k = 0; reqs = 0;
            end
         end
         trig_prev = rst_n && cpu_en && vid_req && !cpu_stall && !frame_start;
         st_prev   = cpu_stall;
         fs_prev   = rst_n && frame_start;
         req_prev  = vid_req;
      end
   end

   task automatic step(input logic fs, input logic act);
      @(posedge clk); #1;
      frame_start = fs;
      pix_active  = act;
   endtask

   initial begin
      rst_n = 1'b0;
      frame_start = 1'b0;
      pix_active  = 1'b0;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      for (int f = 0; f < FRAMES; f++) begin
         step(1'b1, 1'b0);
         for (int v = 0; v < 40 + f; v++) step(1'b0, 1'b0);
         for (int l = 0; l < LINES; l++) begin
            for (int x = 0; x < LINE_PIX; x++) step(1'b0, 1'b1);
            for (int h = 0; h < 20 + ((f * 3 + l * 2) % 7); h++) step(1'b0, 1'b0);
         end
      end
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      for (int t = 0; t < 400 && wr_done < N_WR; t++) step(1'b0, 1'b0);
      repeat (4) @(posedge clk);
      // R9: every held write reached memory
      chk(wr_done == N_WR, "R9 write count", wr_done, N_WR);
      for (int n = 0; n < N_WR; n++)
         chk(mem[WR_BASE + n] == wr_word(n), "R9 write data",
             mem[WR_BASE + n], wr_word(n));
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL R7 watchdog expired actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule